// File: doc/BRIEF.md
# Microsecond Event Timer with Timestamp

This block is a small memory-mapped system timer. It holds two 32-bit counters that share one register window. The first is an event down-counter: software loads a tick count and starts it, and the block raises a flag and a level interrupt when the count runs out. The second is a timestamp that counts up on its own from reset and cannot be written. Both counters step once per microsecond. A prescaler divides the bus clock down to that rate, and the number of bus clocks per microsecond is a parameter.

Software loads the count, then writes the control byte to start the counter in one-shot or periodic mode. When the interrupt arrives, it reads the flag to find out whether this timer raised it, and writes a one to the flag to acknowledge it. To reprogram the counter safely, software first writes a control value that has only the flag bit set. That write halts counting and clears any pending flag, and the new count can then be loaded. In periodic mode with reload set, the counter reloads on its own from the value last written to it.

Top module: `usec_event_timer`

## Requirements
- R1: After reset, the count register, the timestamp, the control byte and `irq` all read as zero.
- R2: The timestamp at offset 0x08 increases by one every CLK_MHZ bus cycles from reset and wraps at 32 bits. Writes to 0x08 do not change it.
- R3: A write to offset 0x00 updates only the byte lanes whose `wstrb` bit is 1. Reading 0x00 returns the current count. Each such write also saves the resulting value as the reload value.
- R4: The control byte sits at offset 0x14 in lane 0: bit 0 enable, bit 1 periodic, bit 2 reload, bit 7 terminal-count flag. Bits 6:3 and 31:8 read as zero. A control write with `wstrb[0]` low has no effect.
- R5: While enable is 1, the count drops by one every CLK_MHZ cycles. The first decrement comes CLK_MHZ cycles after the edge that set enable. While enable is 0, the count holds.
- R6: In one-shot mode (periodic 0), a tick at count 1 or count 0 sets the flag, clears enable, and leaves the count at zero.
- R7: In periodic mode with reload 1, a tick at count 1 sets the flag and loads the reload value. Enable stays set.
- R8: In periodic mode with reload 0, a tick at count 1 sets the flag and the count becomes 0. The next tick wraps the count to 0xFFFFFFFF and counting continues.
- R9: `irq` equals the flag. A control write with bit 7 set clears the flag, unless an expiry sets it in the same cycle. A control write with bit 7 clear leaves the flag unchanged.
- R10: A control write of 0x80 stops counting: the count then holds and `irq` goes low.
- R11: Reads from any offset other than 0x00, 0x08 and 0x14 return zero, and writes to them change no state.
- R12: If a write to 0x00 lands in the same cycle as a tick, the written value wins over the decrement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW | Byte offset of the access |
| wdata | input | CW | Write data |
| wstrb | input | CW/8 | Byte-lane write strobes |
| wen | input | 1 | Write enable, one cycle per write |
| ren | input | 1 | Read enable; `rdata` is combinational from the current state |
| rdata | output | CW | Read data; zero when `ren` is low |
| irq | output | 1 | Level interrupt, high while the flag is set |

## Verification
The assertions assume that `wen` is never high in the cycle they examine, unless the property itself names the write. They also assume that the address matches one of the three mapped offsets exactly, since the decode compares the full offset. The stimulus follows this by driving each write for exactly one clock. Between bus operations the bench idles with `wen` low, so the hold and stepping properties apply in those stretches. Reads are combinational and alter no state, so the bench may read at any moment while the counters run.

// File: rtl/utmr_pkg.sv
package utmr_pkg;
    localparam int unsigned OFS_COUNT = 32'h00;
    localparam int unsigned OFS_STAMP = 32'h08;
    localparam int unsigned OFS_CTRL  = 32'h14;

    localparam int unsigned BIT_EN  = 0;
    localparam int unsigned BIT_PER = 1;
    localparam int unsigned BIT_REL = 2;
    localparam int unsigned BIT_TC  = 7;
endpackage

// File: rtl/utmr_prescale.sv
module utmr_prescale #(
    parameter int unsigned DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned PW = (DIV < 2) ? 1 : $clog2(DIV);
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q + 1'b1;
        if (!run || tick) cnt_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/utmr_stamp.sv
module utmr_stamp #(
    parameter int unsigned CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    output logic [CW-1:0] value
);
    logic [CW-1:0] ts_d, ts_q;

    always_comb begin
        ts_d = ts_q;
        if (tick) ts_d = ts_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_d;
    end

    assign value = ts_q;
endmodule

// File: rtl/utmr_event.sv
module utmr_event #(
    parameter int unsigned CW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [CW/8-1:0] lane_we,
    input  logic [CW-1:0]   wdata,
    input  logic            ctl_we,
    input  logic            en_wd,
    input  logic            per_wd,
    input  logic            rel_wd,
    input  logic            ack_wd,
    output logic [CW-1:0]   count,
    output logic            en,
    output logic            per,
    output logic            rel,
    output logic            tc
);
    localparam int unsigned NB = CW / 8;

    typedef struct packed {
        logic [CW-1:0] count;
        logic [CW-1:0] shadow;
        logic          en;
        logic          per;
        logic          rel;
        logic          tc;
    } ev_state_t;

    ev_state_t st_d, st_q;
    logic [CW-1:0] merged;
    logic          expire;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        merged = st_q.count;

        if (st_q.en && tick) begin
            if (st_q.count == CW'(1) || (st_q.count == '0 && !st_q.per)) begin
                expire  = 1'b1;
                st_d.tc = 1'b1;
                if (!st_q.per) begin
                    st_d.count = '0;
                    st_d.en    = 1'b0;
                end else if (st_q.rel) begin
                    st_d.count = st_q.shadow;
                end else begin
                    st_d.count = st_q.count - 1'b1;
                end
            end else begin
                st_d.count = st_q.count - 1'b1;
            end
        end

        if (|lane_we) begin
            for (int b = 0; b < NB; b++) begin
                if (lane_we[b]) merged[8*b +: 8] = wdata[8*b +: 8];
            end
            st_d.count  = merged;
            st_d.shadow = merged;
        end

        if (ctl_we) begin
            st_d.en  = en_wd;
            st_d.per = per_wd;
            st_d.rel = rel_wd;
            if (ack_wd && !expire) st_d.tc = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.count;
    assign en    = st_q.en;
    assign per   = st_q.per;
    assign rel   = st_q.rel;
    assign tc    = st_q.tc;
endmodule

// File: rtl/usec_event_timer.sv
module usec_event_timer #(
    parameter int unsigned CLK_MHZ = 100,
    parameter int unsigned CW      = 32,
    parameter int unsigned AW      = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr,
    input  logic [CW-1:0]   wdata,
    input  logic [CW/8-1:0] wstrb,
    input  logic            wen,
    input  logic            ren,
    output logic [CW-1:0]   rdata,
    output logic            irq
);
    import utmr_pkg::*;

    localparam int unsigned NB = CW / 8;

    logic          ts_tick, ev_tick;
    logic [CW-1:0] ts_val, ev_count;
    logic          ev_en, ev_per, ev_rel, ev_tc;
    logic          hit_cnt, hit_ts, hit_ctl;
    logic [NB-1:0] cnt_lanes;
    logic          ctl_wr;

    assign hit_cnt   = (addr == AW'(OFS_COUNT));
    assign hit_ts    = (addr == AW'(OFS_STAMP));
    assign hit_ctl   = (addr == AW'(OFS_CTRL));
    assign cnt_lanes = (wen && hit_cnt) ? wstrb : '0;
    assign ctl_wr    = wen && hit_ctl && wstrb[0];

    utmr_prescale #(.DIV(CLK_MHZ)) u_ts_pre (
        .clk(clk), .rst_n(rst_n), .run(1'b1), .tick(ts_tick)
    );

    utmr_prescale #(.DIV(CLK_MHZ)) u_ev_pre (
        .clk(clk), .rst_n(rst_n), .run(ev_en), .tick(ev_tick)
    );

    utmr_stamp #(.CW(CW)) u_stamp (
        .clk(clk), .rst_n(rst_n), .tick(ts_tick), .value(ts_val)
    );

    utmr_event #(.CW(CW)) u_event (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (ev_tick),
        .lane_we(cnt_lanes),
        .wdata  (wdata),
        .ctl_we (ctl_wr),
        .en_wd  (wdata[BIT_EN]),
        .per_wd (wdata[BIT_PER]),
        .rel_wd (wdata[BIT_REL]),
        .ack_wd (wdata[BIT_TC]),
        .count  (ev_count),
        .en     (ev_en),
        .per    (ev_per),
        .rel    (ev_rel),
        .tc     (ev_tc)
    );

    always_comb begin
        rdata = '0;
        if (ren) begin
            if (hit_cnt) begin
                rdata = ev_count;
            end else if (hit_ts) begin
                rdata = ts_val;
            end else if (hit_ctl) begin
                rdata[BIT_EN]  = ev_en;
                rdata[BIT_PER] = ev_per;
                rdata[BIT_REL] = ev_rel;
                rdata[BIT_TC]  = ev_tc;
            end
        end
    end

    assign irq = ev_tc;
endmodule

// File: rtl/utmr_checker.sv
module utmr_checker #(
    parameter int unsigned CW = 32,
    parameter int unsigned AW = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic [AW-1:0]   addr,
    input logic [CW-1:0]   wdata,
    input logic [CW/8-1:0] wstrb,
    input logic            wen,
    input logic            ren,
    input logic [CW-1:0]   rdata,
    input logic [CW-1:0]   ts_val,
    input logic [CW-1:0]   ev_count,
    input logic            ev_en,
    input logic            ev_per,
    input logic            ev_tick,
    input logic            ev_tc
);
    import utmr_pkg::*;

    logic ack_wr, mapped;
    assign ack_wr = wen && (addr == AW'(OFS_CTRL)) && wstrb[0] && wdata[BIT_TC];
    assign mapped = (addr == AW'(OFS_COUNT)) || (addr == AW'(OFS_STAMP)) ||
                    (addr == AW'(OFS_CTRL));

    // R2: the timestamp only ever moves forward by one
    a_r2_stamp_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_val != $past(ts_val)) |-> (ts_val == $past(ts_val) + CW'(1)));

    // R5: between ticks and without writes the count stays put
    a_r5_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_en && !ev_tick && !wen) |=> $stable(ev_count));

    // R6: one-shot expiry raises the flag, drops enable, parks at zero
    a_r6_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_en && !ev_per && ev_tick && ev_count == CW'(1) && !wen)
        |=> (ev_tc && !ev_en && ev_count == '0));

    // R9: the flag stays set until acknowledged
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tc && !ack_wr) |=> ev_tc);

    // R10: a stopped counter holds its value while the bus is quiet
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_en && !wen) |=> $stable(ev_count));

    // R11: unmapped offsets read as zero
    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ren && !mapped) |-> (rdata == '0));
endmodule

bind usec_event_timer utmr_checker #(.CW(CW), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wdata   (wdata),
    .wstrb   (wstrb),
    .wen     (wen),
    .ren     (ren),
    .rdata   (rdata),
    .ts_val  (ts_val),
    .ev_count(ev_count),
    .ev_en   (ev_en),
    .ev_per  (ev_per),
    .ev_tick (ev_tick),
    .ev_tc   (ev_tc)
);

// File: tb/sim_usec_event_timer.sv
module sim_usec_event_timer;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        wen = 1'b0;
    logic        ren = 1'b0;
    logic [31:0] rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    usec_event_timer #(.CLK_MHZ(DIV), .CW(32), .AW(5)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wstrb(wstrb),
        .wen(wen), .ren(ren), .rdata(rdata), .irq(irq)
    );

    // Behavioural reference model
    int          m_tpre, m_epre;
    logic [31:0] m_ts, m_cnt, m_shadow, merged, n_cnt;
    logic        m_en, m_per, m_rel, m_tc;
    logic        n_en, n_tc, tstick, etick, expd;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tpre = 0; m_epre = 0; m_ts = 0; m_cnt = 0; m_shadow = 0;
            m_en = 0; m_per = 0; m_rel = 0; m_tc = 0;
        end else begin
            tstick = (m_tpre == DIV - 1);
            m_tpre = tstick ? 0 : m_tpre + 1;
            if (tstick) m_ts = m_ts + 1;
            etick  = m_en && (m_epre == DIV - 1);
            m_epre = (!m_en || etick) ? 0 : m_epre + 1;
            n_cnt = m_cnt; n_en = m_en; n_tc = m_tc; expd = 0;
            if (etick) begin
                if (m_cnt == 1 || (m_cnt == 0 && !m_per)) begin
                    expd = 1; n_tc = 1;
                    if (!m_per) begin n_cnt = 0; n_en = 0; end
                    else if (m_rel) n_cnt = m_shadow;
                    else n_cnt = m_cnt - 1;
                end else n_cnt = m_cnt - 1;
            end
            if (wen && addr == 5'h00 && wstrb != 0) begin
                merged = m_cnt;
                for (int b = 0; b < 4; b++)
                    if (wstrb[b]) merged[8*b +: 8] = wdata[8*b +: 8];
                n_cnt = merged; m_shadow = merged;
            end
            if (wen && addr == 5'h14 && wstrb[0]) begin
                n_en = wdata[0]; m_per = wdata[1]; m_rel = wdata[2];
                if (wdata[7] && !expd) n_tc = 0;
            end
            m_cnt = n_cnt; m_en = n_en; m_tc = n_tc;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R9: irq compared with the model flag on every clock
    always @(negedge clk) if (rst_n && !done) check("R9 irq level", {31'b0, irq}, {31'b0, m_tc});

    function automatic logic [31:0] m_ctl();
        return {24'b0, m_tc, 4'b0, m_rel, m_per, m_en};
    endfunction

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s);
        addr = a; wdata = d; wstrb = s; wen = 1'b1;
        @(negedge clk);
        wen = 1'b0; wstrb = '0;
    endtask

    task automatic bus_rd(input string req, input logic [4:0] a, input logic [31:0] exp);
        addr = a; ren = 1'b1;
        #1;
        check(req, rdata, exp);
        ren = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 2000 && !irq; i++) @(negedge clk);
    endtask

    logic [31:0] held;

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        bus_rd("R1 count", 5'h00, 32'h0);
        bus_rd("R1 ctrl", 5'h14, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        // R2 timestamp runs and ignores writes
        idle(9);
        bus_rd("R2 stamp", 5'h08, m_ts);
        bus_wr(5'h08, 32'hFFFF_0000, 4'hF);
        bus_rd("R2 stamp after write", 5'h08, m_ts);
        // R3 byte-lane writes
        bus_wr(5'h00, 32'h1234_5678, 4'hF);
        bus_rd("R3 full write", 5'h00, 32'h1234_5678);
        bus_wr(5'h00, 32'h0000_AA00, 4'b0010);
        bus_rd("R3 lane write", 5'h00, 32'h1234_AA78);
        // R4 control layout and lane 0 gating
        bus_wr(5'h14, 32'h0000_007E, 4'h1);
        bus_rd("R4 ctrl fields", 5'h14, 32'h0000_0006);
        bus_wr(5'h14, 32'h0000_0001, 4'b0010);
        bus_rd("R4 lane0 off", 5'h14, 32'h0000_0006);
        bus_wr(5'h14, 32'h0, 4'h1);
        // R5 decrement timing after enable
        bus_wr(5'h00, 32'd20, 4'hF);
        bus_wr(5'h14, 32'h01, 4'h1);
        idle(DIV - 1);
        addr = 5'h00; ren = 1'b1; #1;
        check("R5 before first tick", rdata, 32'd20);
        ren = 1'b0;
        @(negedge clk);
        bus_rd("R5 first tick", 5'h00, 32'd19);
        // R6 one-shot expiry
        wait_irq();
        bus_rd("R6 ctrl after expiry", 5'h14, 32'h80);
        bus_rd("R6 count parked", 5'h00, 32'h0);
        idle(2 * DIV);
        bus_rd("R6 count still zero", 5'h00, 32'h0);
        // R9 acknowledge rules
        bus_wr(5'h14, 32'h00, 4'h1);
        bus_rd("R9 zero write keeps flag", 5'h14, 32'h80);
        bus_wr(5'h14, 32'h80, 4'h1);
        bus_rd("R9 ack clears flag", 5'h14, 32'h00);
        check("R9 irq low", {31'b0, irq}, 32'h0);
        // R7 periodic with reload
        bus_wr(5'h00, 32'd16, 4'hF);
        bus_wr(5'h14, 32'h07, 4'h1);
        wait_irq();
        bus_rd("R7 reloaded", 5'h00, 32'd16);
        bus_wr(5'h14, 32'h87, 4'h1);
        bus_rd("R7 ack keeps running", 5'h14, 32'h07);
        wait_irq();
        bus_rd("R7 second period", 5'h00, 32'd16);
        // R10 stop write
        bus_wr(5'h14, 32'h80, 4'h1);
        bus_rd("R10 ctrl cleared", 5'h14, 32'h00);
        check("R10 irq low", {31'b0, irq}, 32'h0);
        held = m_cnt;
        idle(3 * DIV);
        bus_rd("R10 count holds", 5'h00, held);
        // R8 periodic without reload
        bus_wr(5'h00, 32'd15, 4'hF);
        bus_wr(5'h14, 32'h03, 4'h1);
        wait_irq();
        bus_rd("R8 reaches zero", 5'h00, 32'h0);
        idle(DIV - 1);
        bus_rd("R8 wraps", 5'h00, 32'hFFFF_FFFF);
        bus_rd("R8 still enabled", 5'h14, 32'h83);
        // R12 write collides with a tick
        for (int i = 0; i < 20 && !(m_en && m_epre == DIV - 1); i++) @(negedge clk);
        bus_wr(5'h00, 32'h0000_0100, 4'hF);
        bus_rd("R12 write wins", 5'h00, 32'h0000_0100);
        bus_wr(5'h14, 32'h80, 4'h1);
        // R11 unmapped offsets
        held = m_cnt;
        bus_wr(5'h04, 32'hFFFF_FFFF, 4'hF);
        bus_wr(5'h0C, 32'hFFFF_FFFF, 4'hF);
        bus_wr(5'h10, 32'hFFFF_FFFF, 4'hF);
        bus_wr(5'h18, 32'hFFFF_FFFF, 4'hF);
        bus_rd("R11 read 0x04", 5'h04, 32'h0);
        bus_rd("R11 read 0x10", 5'h10, 32'h0);
        bus_rd("R11 read 0x1C", 5'h1C, 32'h0);
        bus_rd("R11 count untouched", 5'h00, held);
        bus_rd("R11 ctrl untouched", 5'h14, 32'h0);
        bus_rd("R2 stamp final", 5'h08, m_ts);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 50000; i++) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule